// File: doc/BRIEF.md
# Dual-Threshold PWM Channel

This block is one pulse-width modulator channel. A 16-bit counter advances on enable pulses from a programmable prescaler and runs from zero up to a programmed period value. It then wraps to zero. Two thresholds place the pulse inside each period. The pin takes its active level once the count is strictly above the rise threshold. It goes back to its inactive level once the count is strictly above the fall threshold. Each of the two levels can be driven high, driven low, or released to high impedance, which is shown on a separate output-enable line.

Software programs the channel through two 32-bit registers. Each register has four word addresses: a plain write, a set-bits write, a clear-bits write and a toggle-bits write. The counter and comparators work from shadow copies of the registers. These copies reload only at a period wrap, or continuously while the channel is disabled, so a running waveform never shows a half-updated setting.

A clock-forwarding override can replace the waveform. It puts one of two raw reference clocks (slow or fast) directly on the pin.

Top module: `pwm_dual_thresh`

## Requirements
- R1: After reset both registers read as zero, and the pin is released (pwmOe=0, pwmOut=0).
- R2: busAddr[4] selects the register: 0 is the threshold register and 1 is the period register. busAddr[3:2] selects the write action: 0 writes the value, 1 sets the written one-bits, 2 clears them and 3 toggles them. Writes with busAddr[1:0] not equal to zero are ignored. A read at any of a register's four addresses returns that register.
- R3: Bits 31:25 of the period register always read zero. Writes to them, including set and toggle writes, have no effect.
- R4: The threshold register holds the rise threshold in bits 15:0 and the fall threshold in bits 31:16. The period value is in period-register bits 15:0. The count runs 0,1,...,period and then 0 again. The channel is in its active state exactly when count > rise and not count > fall.
- R5: Period-register bits 18:16 set the prescaler: codes 0..7 divide by 1, 2, 4, 8, 16, 64, 256 and 1024. After enable, the count advances once every N clocks.
- R6: Period-register bits 20:19 give the active-state level and bits 22:21 give the inactive-state level. Code 1 drives low, code 2 drives high, and codes 0 and 3 release the pin (pwmOe=0, pwmOut=0).
- R7: While chanEn is low, the counter and prescaler are held at zero and the pin shows the inactive level. After chanEn rises, counting restarts from zero.
- R8: While the channel is enabled, a register write changes the waveform only from the next period wrap onward.
- R9: When period-register bit 23 is set, pwmOe=1 and pwmOut follows refFastClk if bit 24 is 1, or refSlowClk if bit 24 is 0. This applies immediately and regardless of chanEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel run enable |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 5 | Byte address within the channel |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed register |
| refSlowClk | input | 1 | Slow reference clock for forwarding |
| refFastClk | input | 1 | Fast reference clock for forwarding |
| pwmOut | output | 1 | Pin data |
| pwmOe | output | 1 | Pin drive enable |

## Verification
The waveform is tried with five threshold arrangements:
- an ordinary pulse inside the period;
- a rise threshold of zero;
- a fall threshold below the rise threshold, so there is never an active state;
- a fall threshold beyond the period;
- equal thresholds.

The same runs cover four prescaler settings and every level code, including released pins in either state. A rise/fall swap shows up in the first arrangement. An off-by-one in the strict comparisons shows up in the zero and equal cases. A wrong wrap point shows up when the pattern is checked over two whole periods.

A threshold rewrite in the middle of a period shows whether the update waits for the wrap. A disable followed by a re-enable shows that the count restarts.

// File: rtl/pwm_dt_pkg.sv
`timescale 1ns/1ps
package pwm_dt_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 5;
  localparam int CNT_W   = 16;
  localparam int DIV_W   = 3;
  localparam int LVL_W   = 2;
  localparam int PRE_W   = 10;
  localparam int DIV_LSB = CNT_W;
  localparam int ALV_LSB = DIV_LSB + DIV_W;
  localparam int ILV_LSB = ALV_LSB + LVL_W;
  localparam int ATT_BIT = ILV_LSB + LVL_W;
  localparam int SEL_BIT = ATT_BIT + 1;
  localparam logic [REG_W-1:0] PER_MASK = REG_W'((64'd1 << (SEL_BIT + 1)) - 64'd1);

  typedef enum logic [1:0] {OP_WRITE, OP_SET, OP_CLEAR, OP_TOGGLE} wr_op_e;
  typedef enum logic [LVL_W-1:0] {LVL_REL0, LVL_LOW, LVL_HIGH, LVL_REL3} lvl_e;

  typedef struct packed {
    logic [CNT_W-1:0] riseThr;
    logic [CNT_W-1:0] fallThr;
    logic [CNT_W-1:0] period;
    logic [DIV_W-1:0] divSel;
    lvl_e             actLvl;
    lvl_e             inLvl;
  } cfg_t;

  typedef struct packed {
    logic hold;
    logic attach;
    logic attachFast;
  } strobe_t;

  function automatic logic [REG_W-1:0] applyOp(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] data,
                                                input wr_op_e op);
    case (op)
      OP_SET:    return cur | data;
      OP_CLEAR:  return cur & ~data;
      OP_TOGGLE: return cur ^ data;
      default:   return data;
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] divLimit(input logic [DIV_W-1:0] sel);
    logic [3:0] sh;
    case (sel)
      3'd5:    sh = 4'd6;
      3'd6:    sh = 4'd8;
      3'd7:    sh = 4'd10;
      default: sh = {1'b0, sel};
    endcase
    return PRE_W'((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/pwm_dt_ctrl.sv
`timescale 1ns/1ps
module pwm_dt_ctrl
  import pwm_dt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chanEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  output cfg_t              cfg,
  output strobe_t           strb
);
  logic [REG_W-1:0] thrReg;
  logic [REG_W-1:0] perReg;
  logic             hit;
  logic             selPer;
  wr_op_e           op;

  assign hit    = busWr && (busAddr[1:0] == 2'b00);
  assign selPer = busAddr[4];
  assign op     = wr_op_e'(busAddr[3:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thrReg <= '0;
      perReg <= '0;
    end else if (hit) begin
      if (selPer) perReg <= applyOp(perReg, busWrData, op) & PER_MASK;
      else        thrReg <= applyOp(thrReg, busWrData, op);
    end
  end

  assign busRdData = selPer ? perReg : thrReg;

  always_comb begin
    cfg.riseThr = thrReg[CNT_W-1:0];
    cfg.fallThr = thrReg[2*CNT_W-1:CNT_W];
    cfg.period  = perReg[CNT_W-1:0];
    cfg.divSel  = perReg[DIV_LSB +: DIV_W];
    cfg.actLvl  = lvl_e'(perReg[ALV_LSB +: LVL_W]);
    cfg.inLvl   = lvl_e'(perReg[ILV_LSB +: LVL_W]);
    strb.hold       = !chanEn;
    strb.attach     = perReg[ATT_BIT];
    strb.attachFast = perReg[SEL_BIT];
  end

  // R3: reserved bits never become set
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (perReg & ~PER_MASK) == '0);

  // R2: a set-alias write leaves every written one-bit set
  a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !selPer && op == OP_SET) |=> ((thrReg & $past(busWrData)) == $past(busWrData)));
endmodule

// File: rtl/pwm_dt_path.sv
`timescale 1ns/1ps
module pwm_dt_path
  import pwm_dt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cfg_t    cfg,
  input  strobe_t strb,
  input  logic    refSlowClk,
  input  logic    refFastClk,
  output logic    pwmOut,
  output logic    pwmOe
);
  cfg_t             shCfg;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] preLim;
  logic             tick;
  logic             wrap;
  logic             isActive;
  lvl_e             curLvl;
  logic             lvlOut;
  logic             lvlOe;

  assign preLim = divLimit(shCfg.divSel);
  assign tick   = pre >= preLim;
  assign wrap   = tick && (cnt >= shCfg.period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pre   <= '0;
      shCfg <= '0;
    end else if (strb.hold) begin
      cnt   <= '0;
      pre   <= '0;
      shCfg <= cfg;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (wrap) begin
        cnt   <= '0;
        shCfg <= cfg;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign isActive = !strb.hold && (cnt > shCfg.riseThr) && !(cnt > shCfg.fallThr);
  assign curLvl   = isActive ? shCfg.actLvl : shCfg.inLvl;

  always_comb begin
    case (curLvl)
      LVL_LOW:  begin lvlOe = 1'b1; lvlOut = 1'b0; end
      LVL_HIGH: begin lvlOe = 1'b1; lvlOut = 1'b1; end
      default:  begin lvlOe = 1'b0; lvlOut = 1'b0; end
    endcase
  end

  always_comb begin
    if (strb.attach) begin
      pwmOe  = 1'b1;
      pwmOut = strb.attachFast ? refFastClk : refSlowClk;
    end else begin
      pwmOe  = lvlOe;
      pwmOut = lvlOut;
    end
  end

  // R7: a held channel has its count at zero one cycle later
  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strb.hold |=> (cnt == '0));

  // R4: count never passes the period in use
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= shCfg.period);

  // R5: prescaler stays within its limit
  a_r5_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= preLim);

  // R8: running shadow settings change only at a wrap
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.hold && !wrap) |=> $stable(shCfg));

  // R9: forwarding always drives the pin
  a_r9_attach_drives: assert property (@(posedge clk) disable iff (!rst_n)
    strb.attach |-> pwmOe);

  // R6: a released pin carries a zero data value
  a_r6_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwmOe |-> !pwmOut);
endmodule

// File: rtl/pwm_dual_thresh.sv
`timescale 1ns/1ps
module pwm_dual_thresh
  import pwm_dt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chanEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  input  logic              refSlowClk,
  input  logic              refFastClk,
  output logic              pwmOut,
  output logic              pwmOe
);
  cfg_t    cfg;
  strobe_t strb;

  pwm_dt_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .chanEn    (chanEn),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .cfg       (cfg),
    .strb      (strb)
  );

  pwm_dt_path i_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .strb       (strb),
    .refSlowClk (refSlowClk),
    .refFastClk (refFastClk),
    .pwmOut     (pwmOut),
    .pwmOe      (pwmOe)
  );
endmodule

// File: tb/test_pwm_dual_thresh.sv
`timescale 1ns/1ps
module test_pwm_dual_thresh;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chanEn = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        refSlowClk = 1'b0;
  logic        refFastClk = 1'b0;
  logic        pwmOut;
  logic        pwmOe;

  int checks = 0;
  int fails = 0;
  int edgeCnt = 0;

  localparam logic [1:0] L_Z = 2'd0, L_LO = 2'd1, L_HI = 2'd2, L_Z3 = 2'd3;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] i;
    logic [15:0] p;
    logic [2:0]  dv;
    logic [1:0]  al;
    logic [1:0]  il;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'd2, 16'd5,  16'd7, 3'd0, L_HI, L_LO},
    '{16'd0, 16'd3,  16'd4, 3'd1, L_LO, L_HI},
    '{16'd5, 16'd2,  16'd9, 3'd0, L_HI, L_LO},
    '{16'd1, 16'd20, 16'd6, 3'd2, L_HI, L_Z},
    '{16'd3, 16'd3,  16'd5, 3'd3, L_Z3, L_HI}
  };

  pwm_dual_thresh i_pwm_dual_thresh (
    .clk(clk), .rst_n(rst_n), .chanEn(chanEn), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .refSlowClk(refSlowClk),
    .refFastClk(refFastClk), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!chanEn) edgeCnt <= 0;
    else         edgeCnt <= edgeCnt + 1;
  end

  function automatic int divOf(input logic [2:0] dv);
    case (dv)
      3'd5: return 64;
      3'd6: return 256;
      3'd7: return 1024;
      default: return 1 << dv;
    endcase
  endfunction

  function automatic logic [1:0] pinOf(input logic [1:0] lvl);
    case (lvl)
      L_LO: return 2'b10;
      L_HI: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] expPin(input int cnt, input int a, input int i,
                                        input logic [1:0] al, input logic [1:0] il);
    return ((cnt > a) && !(cnt > i)) ? pinOf(al) : pinOf(il);
  endfunction

  function automatic logic [31:0] perWord(input logic [15:0] p, input logic [2:0] dv,
                                          input logic [1:0] al, input logic [1:0] il);
    return {9'd0, il, al, dv, p};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [4:0] addr, input logic [31:0] data);
    @(negedge clk);
    busWr = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] addr, input logic [31:0] exp, input string req);
    busAddr = addr;
    #1;
    chk(req, busRdData, exp);
  endtask

  task automatic pinChk(input string req, input logic [1:0] exp);
    chk(req, {30'd0, pwmOe, pwmOut}, {30'd0, exp});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, 32'h0, "R1 threshold reg");
    rd(5'h10, 32'h0, "R1 period reg");
    pinChk("R1 pin released", 2'b00);

    // R2 aliases on the threshold register
    wr(5'h00, 32'h00F0_0F0F);
    rd(5'h00, 32'h00F0_0F0F, "R2 plain write");
    wr(5'h04, 32'h0000_F000);
    rd(5'h08, 32'h00F0_FF0F, "R2 set alias");
    wr(5'h08, 32'h00F0_0000);
    rd(5'h04, 32'h0000_FF0F, "R2 clear alias");
    wr(5'h0C, 32'hFFFF_0000);
    rd(5'h0C, 32'hFFFF_FF0F, "R2 toggle alias");
    wr(5'h01, 32'h0);
    rd(5'h00, 32'hFFFF_FF0F, "R2 misaligned write ignored");

    // R3 reserved bits
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, 32'h01FF_FFFF, "R3 reserved after all-ones");
    wr(5'h1C, 32'h0300_0000);
    rd(5'h14, 32'h00FF_FFFF, "R3 toggle leaves reserved zero");
    wr(5'h14, 32'hFE00_0000);
    rd(5'h18, 32'h00FF_FFFF, "R3 set of reserved ignored");

    // R9 clock forwarding, slow then fast, independent of chanEn
    wr(5'h10, 32'h0080_0000);
    refSlowClk = 1'b1; refFastClk = 1'b0; #1;
    pinChk("R9 slow high", 2'b11);
    refSlowClk = 1'b0; refFastClk = 1'b1; #1;
    pinChk("R9 slow low", 2'b10);
    wr(5'h14, 32'h0100_0000);
    chanEn = 1'b1; #1;
    pinChk("R9 fast high", 2'b11);
    refFastClk = 1'b0; refSlowClk = 1'b1; #1;
    pinChk("R9 fast low", 2'b10);
    chanEn = 1'b0;

    // R4 R5 R6 vector table
    for (int v = 0; v < NV; v++) begin
      vec_t cv;
      int d;
      int n;
      cv = VECS[v];
      d = divOf(cv.dv);
      n = 2 * (int'(cv.p) + 1) * d + 3;
      wr(5'h00, {cv.i, cv.a});
      wr(5'h10, perWord(cv.p, cv.dv, cv.al, cv.il));
      @(negedge clk);
      @(negedge clk);
      pinChk("R7 R6 idle at inactive level", pinOf(cv.il));
      chanEn = 1'b1;
      #1;
      for (int k = 0; k < n; k++) begin
        pinChk("R4 R5 R6 waveform",
               expPin((edgeCnt / d) % (int'(cv.p) + 1), cv.a, cv.i, cv.al, cv.il));
        @(negedge clk);
      end
      chanEn = 1'b0;
      @(negedge clk);
    end

    // R8 mid-period rewrite takes effect at the wrap
    wr(5'h00, {16'd5, 16'd2});
    wr(5'h10, perWord(16'd7, 3'd0, L_HI, L_LO));
    @(negedge clk);
    chanEn = 1'b1;
    while (edgeCnt < 3) begin
      pinChk("R8 before rewrite", expPin(edgeCnt % 8, 2, 5, L_HI, L_LO));
      @(negedge clk);
    end
    wr(5'h00, {16'd5, 16'd6});
    while (edgeCnt < 16) begin
      pinChk("R8 deferred update",
             expPin(edgeCnt % 8, (edgeCnt < 8) ? 2 : 6, 5, L_HI, L_LO));
      @(negedge clk);
    end

    // R7 disable, then restart from zero
    chanEn = 1'b0;
    @(negedge clk);
    pinChk("R7 disabled shows inactive", 2'b10);
    wr(5'h00, {16'd2, 16'd0});
    @(negedge clk);
    pinChk("R7 still inactive", 2'b10);
    chanEn = 1'b1;
    #1;
    while (edgeCnt < 9) begin
      pinChk("R7 restart from zero", expPin(edgeCnt % 8, 0, 2, L_HI, L_LO));
      @(negedge clk);
    end
    chanEn = 1'b0;

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule